// File: doc/BRIEF.md
# Polled Keyboard Input Port

This block is a bus-attached receive port for a single keyboard. The device side hands over one byte at a time with a strobe. The port latches the byte in a data register and raises a ready flag. A processor finds the byte by polling. It reads a status register, and when the ready flag is set it reads the data register. The port never raises a signal toward the processor. All notification goes through status bits that software samples.

The port sits on a 10-bit address bus. Addresses 0 to 511 belong to memory and 512 to 1023 belong to I/O. The data register is at 516. Address 517 is the status register when read and the command register when written. A strap input picks between two decode schemes. In memory-mapped decode, ordinary bus reads and writes at those addresses reach the port. In isolated decode, the port answers only when a separate I/O-select line accompanies the strobe. Read data is combinational from the current register state and is zero whenever the port is not selected.

Top module: `kbd_port`

## Requirements
- R1: With `mode_iso` = 0 (memory-mapped decode), a read at address 516 returns the data register and a read at 517 returns the status register, whatever the value of `io_sel`.
- R2: With `mode_iso` = 1 (isolated decode), the port answers reads and writes at 516 and 517 only while `io_sel` = 1. With `io_sel` = 0, a read returns zero and a write changes no state.
- R3: The status byte has READY at bit 0, OVERRUN at bit 1, and receive-enable at bit 7. All other bits read as zero. Reading the status has no side effect.
- R4: When receive-enable is 1 and `dev_stb` is high at a clock edge, `dev_data` is latched into the data register and READY is 1 from the next cycle on.
- R5: A selected read at 516 returns the latched byte. After that clock edge READY is 0, unless a new byte is captured in the same cycle.
- R6: A byte captured while READY is 1 sets OVERRUN and replaces the old byte. This does not apply when the data register is read in that same cycle; then OVERRUN is unchanged.
- R7: Writing a byte with bit 1 = 1 to 517 clears OVERRUN. If OVERRUN is being set in the same cycle, it stays set.
- R8: Writing to 517 loads receive-enable from bit 7 of the write data. While receive-enable is 0, `dev_stb` is ignored: the data register, READY and OVERRUN do not change.
- R9: A read of any address other than 516 and 517 returns zero and changes no state. A write to 516 is ignored.
- R10: After reset, READY, OVERRUN, receive-enable and the data register are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_iso | input | 1 | Decode strap: 0 memory-mapped, 1 isolated |
| addr | input | 10 | Bus address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| io_sel | input | 1 | I/O command qualifier, used in isolated decode |
| wdata | input | 8 | Write data for the command register |
| rdata | output | 8 | Read data, zero when not selected |
| dev_data | input | 8 | Byte from the keyboard |
| dev_stb | input | 1 | Byte-valid strobe from the keyboard |

## Verification
The bench builds the port with its defaults: a 10-bit address bus and an 8-bit data path. At that size every address in the map can be read in both decode modes with `io_sel` both low and high, so all 4096 combinations are covered. All 256 byte values also pass through the capture and read sequence. Expected read values come from a flag-level model written from the requirements. This small size also reaches the same-cycle collisions between a capture and a data read, and between a capture and an overrun clear.

// File: rtl/kbd_pkg.sv
package kbd_pkg;

    localparam int STAT_RDY_BIT = 0;
    localparam int STAT_OVR_BIT = 1;
    localparam int CTRL_CLR_BIT = 1;
    localparam int CTRL_EN_BIT  = 7;

    typedef struct packed {
        logic en;
        logic ovr;
        logic rdy;
    } kbd_flags_t;

    typedef struct packed {
        logic rd_data;
        logic rd_stat;
        logic wr_ctrl;
    } kbd_sel_t;

endpackage

// File: rtl/kbd_decode.sv
module kbd_decode
    import kbd_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int IO_BASE   = 512,
    parameter int DATA_ADDR = 516,
    parameter int STAT_ADDR = 517
) (
    input  logic              mode_iso,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              io_sel,
    output kbd_sel_t          sel
);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(IO_BASE);

    logic in_window;
    logic qualified;
    logic hit_data;
    logic hit_stat;

    always_comb begin
        in_window = (addr >= A_BASE);
        qualified = mode_iso ? io_sel : in_window;
        hit_data  = qualified && (addr == A_DATA);
        hit_stat  = qualified && (addr == A_STAT);
        sel.rd_data = rd && hit_data;
        sel.rd_stat = rd && hit_stat;
        sel.wr_ctrl = wr && hit_stat;
    end

endmodule

// File: rtl/kbd_state.sv
module kbd_state
    import kbd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  kbd_sel_t      sel,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] dev_data,
    input  logic          dev_stb,
    output kbd_flags_t    flags,
    output logic [DW-1:0] data
);

    typedef struct packed {
        kbd_flags_t    f;
        logic [DW-1:0] byte_r;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic capture;
    logic ovr_set;
    logic ovr_clr;

    always_comb begin
        st_d    = st_q;
        capture = st_q.f.en && dev_stb;
        ovr_set = capture && st_q.f.rdy && !sel.rd_data;
        ovr_clr = sel.wr_ctrl && wdata[CTRL_CLR_BIT];

        if (capture) begin
            st_d.byte_r = dev_data;
            st_d.f.rdy  = 1'b1;
        end else if (sel.rd_data) begin
            st_d.f.rdy  = 1'b0;
        end

        if (ovr_set) begin
            st_d.f.ovr = 1'b1;
        end else if (ovr_clr) begin
            st_d.f.ovr = 1'b0;
        end

        if (sel.wr_ctrl) begin
            st_d.f.en = wdata[CTRL_EN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.f;
    assign data  = st_q.byte_r;

endmodule

// File: rtl/kbd_rdmux.sv
module kbd_rdmux
    import kbd_pkg::*;
#(
    parameter int DW = 8
) (
    input  kbd_sel_t      sel,
    input  kbd_flags_t    flags,
    input  logic [DW-1:0] data,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] status;

    always_comb begin
        status               = '0;
        status[STAT_RDY_BIT] = flags.rdy;
        status[STAT_OVR_BIT] = flags.ovr;
        status[CTRL_EN_BIT]  = flags.en;
        if (sel.rd_data) begin
            rdata = data;
        end else if (sel.rd_stat) begin
            rdata = status;
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/kbd_port.sv
module kbd_port
    import kbd_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DW        = 8,
    parameter int IO_BASE   = 512,
    parameter int DATA_ADDR = 516,
    parameter int STAT_ADDR = 517
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_iso,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              io_sel,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [DW-1:0]     dev_data,
    input  logic              dev_stb
);

    kbd_sel_t      sel;
    kbd_flags_t    flags;
    logic [DW-1:0] st_data;
    logic          st_rdy;
    logic          st_ovr;
    logic          st_en;

    kbd_decode #(
        .ADDR_W   (ADDR_W),
        .IO_BASE  (IO_BASE),
        .DATA_ADDR(DATA_ADDR),
        .STAT_ADDR(STAT_ADDR)
    ) u_decode (
        .mode_iso(mode_iso),
        .addr    (addr),
        .rd      (rd),
        .wr      (wr),
        .io_sel  (io_sel),
        .sel     (sel)
    );

    kbd_state #(
        .DW(DW)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .wdata   (wdata),
        .dev_data(dev_data),
        .dev_stb (dev_stb),
        .flags   (flags),
        .data    (st_data)
    );

    kbd_rdmux #(
        .DW(DW)
    ) u_rdmux (
        .sel  (sel),
        .flags(flags),
        .data (st_data),
        .rdata(rdata)
    );

    assign st_rdy = flags.rdy;
    assign st_ovr = flags.ovr;
    assign st_en  = flags.en;

endmodule

// File: rtl/kbd_port_chk.sv
module kbd_port_chk #(
    parameter int ADDR_W    = 10,
    parameter int DW        = 8,
    parameter int DATA_ADDR = 516,
    parameter int STAT_ADDR = 517
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_iso,
    input logic [ADDR_W-1:0] addr,
    input logic              rd,
    input logic              io_sel,
    input logic              dev_stb,
    input logic [DW-1:0]     rdata,
    input logic              st_rdy,
    input logic              st_ovr,
    input logic              st_en,
    input logic [DW-1:0]     st_data
);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    logic capture;
    logic data_rd;

    assign capture = st_en && dev_stb;
    assign data_rd = rd && (addr == A_DATA) && (!mode_iso || io_sel);

    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> st_rdy);

    p_rd_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !capture) |=> !st_rdy);

    p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && st_rdy && !data_rd) |=> st_ovr);

    p_ignored_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(st_data));

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr != A_DATA && addr != A_STAT) |-> (rdata == '0));

    p_iso_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_iso && !io_sel) |-> (rdata == '0));

endmodule

bind kbd_port kbd_port_chk #(
    .ADDR_W   (ADDR_W),
    .DW       (DW),
    .DATA_ADDR(DATA_ADDR),
    .STAT_ADDR(STAT_ADDR)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_iso(mode_iso),
    .addr    (addr),
    .rd      (rd),
    .io_sel  (io_sel),
    .dev_stb (dev_stb),
    .rdata   (rdata),
    .st_rdy  (st_rdy),
    .st_ovr  (st_ovr),
    .st_en   (st_en),
    .st_data (st_data)
);

// File: tb/test_kbd_port.sv
module test_kbd_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_iso = 1'b0;
    logic [9:0] addr = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic       io_sel = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] dev_data = '0;
    logic       dev_stb = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic       m_rdy = 1'b0;
    logic       m_ovr = 1'b0;
    logic       m_en  = 1'b0;
    logic [7:0] m_data = '0;

    always #10 clk = ~clk;

    kbd_port i_kbd_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_iso(mode_iso),
        .addr    (addr),
        .rd      (rd),
        .wr      (wr),
        .io_sel  (io_sel),
        .wdata   (wdata),
        .rdata   (rdata),
        .dev_data(dev_data),
        .dev_stb (dev_stb)
    );

    // One bus cycle, entered and left at a falling edge.
    task automatic cyc(input logic [9:0] a, input logic r, input logic w,
                       input logic io, input logic [7:0] wd,
                       input logic stb, input logic [7:0] sd, input string tag);
        logic       hit;
        logic       s_d;
        logic       s_s;
        logic [7:0] exp;
        logic       cap;
        logic       rclr;
        addr = a; rd = r; wr = w; io_sel = io; wdata = wd;
        dev_stb = stb; dev_data = sd;
        hit = mode_iso ? io : (a >= 10'd512);
        s_d = hit && (a == 10'd516);
        s_s = hit && (a == 10'd517);
        exp = 8'h00;
        if (r && s_d) exp = m_data;
        else if (r && s_s) exp = {m_en, 5'b0, m_ovr, m_rdy};
        #1;
        if (r) begin
            n_cmp++;
            if (rdata !== exp) begin
                n_bad++;
                $display("FAIL %s addr=%0d iso=%0d io=%0d actual=%02h expected=%02h",
                         tag, a, mode_iso, io, rdata, exp);
            end
        end
        @(posedge clk);
        cap  = m_en && stb;
        rclr = r && s_d;
        if (cap && m_rdy && !rclr) m_ovr = 1'b1;
        else if (w && s_s && wd[1]) m_ovr = 1'b0;
        if (cap) begin
            m_rdy = 1'b1;
            m_data = sd;
        end else if (rclr) begin
            m_rdy = 1'b0;
        end
        if (w && s_s) m_en = wd[7];
        @(negedge clk);
        rd = 1'b0; wr = 1'b0; dev_stb = 1'b0;
    endtask

    task automatic rd_stat(input string tag);
        cyc(10'd517, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, tag);
    endtask

    task automatic rd_data(input string tag);
        cyc(10'd516, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, tag);
    endtask

    task automatic wr_ctrl(input logic [7:0] v, input string tag);
        cyc(10'd517, 1'b0, 1'b1, 1'b1, v, 1'b0, 8'h00, tag);
    endtask

    task automatic strobe(input logic [7:0] v, input string tag);
        cyc(10'd0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, v, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        rd_stat("R10");
        rd_data("R10");

        // R8: strobe ignored while disabled
        strobe(8'h5A, "R8");
        rd_stat("R8");
        rd_data("R8");

        // R8: enable via control bit 7
        wr_ctrl(8'h80, "R8");
        rd_stat("R8");

        // R4 / R5 / R3: every byte value
        for (int v = 0; v < 256; v++) begin
            strobe(8'(v), "R4");
            rd_stat("R3");
            rd_data("R5");
            rd_stat("R5");
        end

        // R6: overrun
        strobe(8'h11, "R6");
        strobe(8'h22, "R6");
        rd_stat("R6");
        rd_data("R6");
        // R7: clear overrun
        wr_ctrl(8'h82, "R7");
        rd_stat("R7");
        // R7: set wins over clear in the same cycle
        strobe(8'h33, "R7");
        cyc(10'd517, 1'b0, 1'b1, 1'b1, 8'h82, 1'b1, 8'h44, "R7");
        rd_stat("R7");
        rd_data("R7");
        wr_ctrl(8'h82, "R7");
        rd_stat("R7");
        // R6: capture during data read does not overrun
        strobe(8'h55, "R6");
        cyc(10'd516, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 8'h66, "R6");
        rd_stat("R6");
        rd_data("R6");

        // R9: write to data address ignored
        strobe(8'h77, "R9");
        cyc(10'd516, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R9");
        rd_stat("R9");

        // R2: isolated mode, writes without io_sel ignored
        mode_iso = 1'b1;
        cyc(10'd517, 1'b0, 1'b1, 1'b0, 8'h02, 1'b0, 8'h00, "R2");
        rd_stat("R2");
        // R8: disable then strobe ignored
        wr_ctrl(8'h00, "R8");
        strobe(8'h99, "R8");
        rd_stat("R8");
        rd_data("R8");
        wr_ctrl(8'h80, "R8");

        // R1 / R2 / R9: full address sweep in both modes
        for (int m = 0; m < 2; m++) begin
            for (int io = 0; io < 2; io++) begin
                mode_iso = m[0];
                strobe(8'hC3, "R4");
                strobe(8'h3C, "R6");
                for (int a = 0; a < 1024; a++) begin
                    string t;
                    if (m == 1 && io == 0) t = "R2";
                    else if (a == 516 || a == 517) t = "R1";
                    else t = "R9";
                    cyc(10'(a), 1'b1, 1'b0, io[0], 8'h00, 1'b0, 8'h00, t);
                end
                mode_iso = 1'b0;
                rd_stat("R9");
                wr_ctrl(8'h82, "R7");
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule